// File: doc/BRIEF.md
# Two-Port Interrupt and Control Register Bank

This block is the register bank of a storage host controller with two ports. A host reaches it through a simple single-cycle register bus. It holds one global control word, one global pending word and, for each port, a control word, an interrupt status word and an interrupt enable word. The control and enable words are changed through separate set and clear addresses. The status words collect event pulses from the port engines and are cleared by writing ones.

The status bits are ANDed with the enables. Each port's result is gated by that port's global enable and placed onto one of four level interrupt lines, chosen by a two-bit steering field. The command-completion bit can be cleared by a read or only by an explicit write, depending on a per-port control bit. The global word also gives a per-port pending summary, a global port-reset output and a one-cycle acknowledge pulse for message interrupts.

Reads return data on `rdData` in the cycle after the request. All register updates, including a clear caused by a read, take effect at the same clock edge.

Top module: `port_irq_regs`

## Requirements
- R1: After reset the global control word reads 0x8100_0000. The global pending word, each port's control, status and enable words, and `intLines` are all zero.
- R2: Global control (byte address 0x0040):
  - Bit 31 is read/write and drives `globalResetOut`. While it is set, both `portResetOut` bits are forced high.
  - Bits 1:0 are read/write port enables.
  - Bit 24 always reads 1.
  - Every other bit reads 0.
- R3: Writing a 1 to global control bit 30 makes `msiAck` high for exactly the cycle after the write. Any other write leaves `msiAck` low.
- R4: Port p has its base at 0x1000 + p·0x2000.
  - A write to base+0x0 sets the written ones of control bits 0, 1, 3 and 13.
  - A write to base+0x4 clears the written ones of those bits.
  - Zeros in the write data change nothing, and both addresses read back the control word.
  - Bit 0 drives `portResetOut[p]`, bit 1 drives `devResetOut[p]` and bit 13 drives `pmEnable[p]`.
- R5: Event bits 11 and 7:0 of port p (`portEvent[p*12 +: 12]`) set the matching sticky bits of the status word at base+0x8. The other event bits are ignored. Writing ones to base+0x8 clears those bits.
- R6: A read of base+0x8 returns the status as it was before the read. When control bit 3 is clear, the read also clears status bit 0 (completion). When control bit 3 is set, the read clears nothing. A read never clears any other status bit.
- R7: When an event pulse and a clear (by write or by read) reach the same status bit in the same cycle, the bit ends set.
- R8: Enable bits 11 and 7:0 are set by writing ones to base+0x10 and cleared by writing ones to base+0x14. Every write to base+0x10 also loads the steering field, bits 31:30, from the write data. Both addresses read back {steering, 18'b0, enables}.
- R9: Port p asserts a request while (status & enable) is nonzero and global enable bit p is set. `intLines[k]` is the OR of the requests of all ports whose steering value equals k (0 to 3).
- R10: Global pending bit p (byte address 0x0044) is set in every cycle in which port p has a nonzero (status & enable), whatever the global enable. It is cleared by writing a 1, and a set in the same cycle wins over the clear.
- R11: A read of any address outside the map returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Register access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte address |
| busWdata | input | 32 | Write data |
| portEvent | input | 24 | Event pulses, 12 per port, port p at bits p*12 +: 12 |
| rdData | output | 32 | Read data, valid the cycle after a read |
| intLines | output | 4 | Level interrupt lines A to D (bit 0 = A) |
| msiAck | output | 1 | One-cycle message-interrupt acknowledge |
| globalResetOut | output | 1 | Global port reset level |
| portResetOut | output | 2 | Per-port reset level |
| devResetOut | output | 2 | Per-port device reset level |
| pmEnable | output | 2 | Per-port port multiplier enable |

## Verification
The bound checker examines the following on every cycle:
- the timing of the acknowledge pulse against global control writes;
- the global reset, port reset and device reset levels after control writes;
- that no interrupt line rises without a bus write or an event in the previous cycle;
- that unmapped reads return zero.

Other behaviour needs the bench's scenarios to show it. This covers the clear-on-read mode against the no-clear mode, an event winning over a same-cycle clear, steering of both ports onto shared or separate lines, and the sticky global pending bit once the port condition has gone. A mixed random phase compares every output with a register model after each access.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  localparam int PORTS = 2;
  localparam int EVW   = 12;
  localparam int DW    = 32;
  localparam int AW    = 16;
  localparam int LINES = 4;
  localparam int PIDW  = (PORTS > 1) ? $clog2(PORTS) : 1;

  localparam logic [AW-1:0] GCTL_ADDR   = 16'h0040;
  localparam logic [AW-1:0] GSTS_ADDR   = 16'h0044;
  localparam logic [AW-1:0] PORT_BASE   = 16'h1000;
  localparam logic [AW-1:0] PORT_STRIDE = 16'h2000;
  localparam logic [AW-1:0] OFS_CSET = 16'h0000;
  localparam logic [AW-1:0] OFS_CCLR = 16'h0004;
  localparam logic [AW-1:0] OFS_STS  = 16'h0008;
  localparam logic [AW-1:0] OFS_ESET = 16'h0010;
  localparam logic [AW-1:0] OFS_ECLR = 16'h0014;

  localparam logic [DW-1:0]  CTL_MASK = 32'h0000_200B;
  localparam logic [EVW-1:0] INT_MASK = 12'h8FF;
  localparam int GRST_BIT = 31;
  localparam int MSI_BIT  = 30;
  localparam int CAP_BIT  = 24;
  localparam int NCOR_BIT = 3;
  localparam int PRST_BIT = 0;
  localparam int DRST_BIT = 1;
  localparam int PM_BIT   = 13;

  typedef enum logic [2:0] {SEL_NONE, SEL_GCTL, SEL_GSTS, SEL_PCTL, SEL_PSTS, SEL_PEN} rdSel_e;

  typedef struct packed {
    logic             gctlWr;
    logic             gstsW1c;
    logic [PORTS-1:0] ctlSet;
    logic [PORTS-1:0] ctlClr;
    logic [PORTS-1:0] stsW1c;
    logic [PORTS-1:0] stsRd;
    logic [PORTS-1:0] enSet;
    logic [PORTS-1:0] enClr;
    rdSel_e           rdSel;
    logic [PIDW-1:0]  rdPort;
  } strobe_t;

  function automatic logic [AW-1:0] portBase(input int p);
    return AW'(PORT_BASE + p * PORT_STRIDE);
  endfunction
endpackage

// File: rtl/port_irq_decode.sv
module port_irq_decode
  import port_irq_pkg::*;
(
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  output strobe_t       st
);
  always_comb begin
    st = '0;
    st.rdSel = SEL_NONE;
    if (busValid) begin
      if (busAddr == GCTL_ADDR) begin
        st.gctlWr = busWrite;
        if (!busWrite) st.rdSel = SEL_GCTL;
      end
      if (busAddr == GSTS_ADDR) begin
        st.gstsW1c = busWrite;
        if (!busWrite) st.rdSel = SEL_GSTS;
      end
      for (int p = 0; p < PORTS; p++) begin
        if (busAddr == portBase(p) + OFS_CSET || busAddr == portBase(p) + OFS_CCLR) begin
          if (busWrite) begin
            st.ctlSet[p] = (busAddr == portBase(p) + OFS_CSET);
            st.ctlClr[p] = (busAddr == portBase(p) + OFS_CCLR);
          end else begin
            st.rdSel  = SEL_PCTL;
            st.rdPort = PIDW'(p);
          end
        end
        if (busAddr == portBase(p) + OFS_STS) begin
          st.stsW1c[p] = busWrite;
          st.stsRd[p]  = !busWrite;
          if (!busWrite) begin
            st.rdSel  = SEL_PSTS;
            st.rdPort = PIDW'(p);
          end
        end
        if (busAddr == portBase(p) + OFS_ESET || busAddr == portBase(p) + OFS_ECLR) begin
          if (busWrite) begin
            st.enSet[p] = (busAddr == portBase(p) + OFS_ESET);
            st.enClr[p] = (busAddr == portBase(p) + OFS_ECLR);
          end else begin
            st.rdSel  = SEL_PEN;
            st.rdPort = PIDW'(p);
          end
        end
      end
    end
  end
endmodule

// File: rtl/port_irq_dp.sv
module port_irq_dp
  import port_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              st,
  input  logic [DW-1:0]        wdata,
  input  logic [PORTS*EVW-1:0] portEvent,
  output logic [DW-1:0]        rdData,
  output logic [LINES-1:0]     intLines,
  output logic                 msiAck,
  output logic                 globalResetOut,
  output logic [PORTS-1:0]     portResetOut,
  output logic [PORTS-1:0]     devResetOut,
  output logic [PORTS-1:0]     pmEnable
);
  logic             gRstQ, msiQ;
  logic [PORTS-1:0] gEnQ, gStsQ, pend;
  logic [DW-1:0]    ctlQ [PORTS];
  logic [EVW-1:0]   stsQ [PORTS];
  logic [EVW-1:0]   enQ [PORTS];
  logic [1:0]       steerQ [PORTS];
  logic [DW-1:0]    rdQ, rdNext;

  for (genvar p = 0; p < PORTS; p++) begin : gPort
    logic [DW-1:0]  ctlR;
    logic [EVW-1:0] stsR, enR, evt, clrMask, wBits;
    logic [1:0]     steerR;

    assign wBits   = wdata[EVW-1:0] & INT_MASK;
    assign evt     = portEvent[p*EVW +: EVW] & INT_MASK;
    assign clrMask = (st.stsW1c[p] ? wdata[EVW-1:0] : '0)
                   | ((st.stsRd[p] && !ctlR[NCOR_BIT]) ? EVW'(1) : '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        ctlR   <= '0;
        stsR   <= '0;
        enR    <= '0;
        steerR <= '0;
      end else begin
        stsR <= (stsR & ~clrMask) | evt;
        if (st.ctlSet[p])      ctlR <= ctlR | (wdata & CTL_MASK);
        else if (st.ctlClr[p]) ctlR <= ctlR & ~(wdata & CTL_MASK);
        if (st.enSet[p]) begin
          enR    <= enR | wBits;
          steerR <= wdata[DW-1 -: 2];
        end else if (st.enClr[p]) begin
          enR <= enR & ~wBits;
        end
      end
    end

    assign ctlQ[p]   = ctlR;
    assign stsQ[p]   = stsR;
    assign enQ[p]    = enR;
    assign steerQ[p] = steerR;
    assign pend[p]   = |(stsR & enR);
    assign portResetOut[p] = ctlR[PRST_BIT] | gRstQ;
    assign devResetOut[p]  = ctlR[DRST_BIT];
    assign pmEnable[p]     = ctlR[PM_BIT];
  end

  always_comb begin
    intLines = '0;
    for (int p = 0; p < PORTS; p++)
      intLines[steerQ[p]] = intLines[steerQ[p]] | (pend[p] & gEnQ[p]);
  end

  always_comb begin
    case (st.rdSel)
      SEL_GCTL: rdNext = (DW'(gRstQ) << GRST_BIT) | (DW'(1) << CAP_BIT) | DW'(gEnQ);
      SEL_GSTS: rdNext = DW'(gStsQ);
      SEL_PCTL: rdNext = ctlQ[st.rdPort];
      SEL_PSTS: rdNext = DW'(stsQ[st.rdPort]);
      SEL_PEN:  rdNext = {steerQ[st.rdPort], {(DW-2-EVW){1'b0}}, enQ[st.rdPort]};
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gRstQ <= 1'b1;
      gEnQ  <= '0;
      gStsQ <= '0;
      msiQ  <= 1'b0;
      rdQ   <= '0;
    end else begin
      if (st.gctlWr) begin
        gRstQ <= wdata[GRST_BIT];
        gEnQ  <= wdata[PORTS-1:0];
      end
      msiQ  <= st.gctlWr & wdata[MSI_BIT];
      gStsQ <= (gStsQ & ~(st.gstsW1c ? wdata[PORTS-1:0] : '0)) | pend;
      rdQ   <= rdNext;
    end
  end

  assign rdData         = rdQ;
  assign msiAck         = msiQ;
  assign globalResetOut = gRstQ;
endmodule

// File: rtl/port_irq_regs.sv
module port_irq_regs
  import port_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [AW-1:0]        busAddr,
  input  logic [DW-1:0]        busWdata,
  input  logic [PORTS*EVW-1:0] portEvent,
  output logic [DW-1:0]        rdData,
  output logic [LINES-1:0]     intLines,
  output logic                 msiAck,
  output logic                 globalResetOut,
  output logic [PORTS-1:0]     portResetOut,
  output logic [PORTS-1:0]     devResetOut,
  output logic [PORTS-1:0]     pmEnable
);
  strobe_t st;

  port_irq_decode u_dec (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .st(st)
  );

  port_irq_dp u_dp (
    .clk(clk), .rst(rst), .st(st), .wdata(busWdata), .portEvent(portEvent),
    .rdData(rdData), .intLines(intLines), .msiAck(msiAck),
    .globalResetOut(globalResetOut), .portResetOut(portResetOut),
    .devResetOut(devResetOut), .pmEnable(pmEnable)
  );
endmodule

// File: rtl/port_irq_regs_chk.sv
module port_irq_regs_chk
  import port_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 busValid,
  input logic                 busWrite,
  input logic [AW-1:0]        busAddr,
  input logic [DW-1:0]        busWdata,
  input logic [PORTS*EVW-1:0] portEvent,
  input logic [DW-1:0]        rdData,
  input logic [LINES-1:0]     intLines,
  input logic                 msiAck,
  input logic                 globalResetOut,
  input logic [PORTS-1:0]     portResetOut,
  input logic [PORTS-1:0]     devResetOut
);
  function automatic logic mapped(input logic [AW-1:0] a);
    logic m;
    m = (a == GCTL_ADDR) || (a == GSTS_ADDR);
    for (int p = 0; p < PORTS; p++)
      m = m || a == portBase(p) + OFS_CSET || a == portBase(p) + OFS_CCLR
            || a == portBase(p) + OFS_STS || a == portBase(p) + OFS_ESET
            || a == portBase(p) + OFS_ECLR;
    return m;
  endfunction

  logic gctlWrite;
  assign gctlWrite = busValid && busWrite && busAddr == GCTL_ADDR;

  AST_MSI_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    msiAck |-> $past(gctlWrite && busWdata[MSI_BIT]));  // R3

  AST_MSI_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (gctlWrite && busWdata[MSI_BIT]) |=> msiAck);  // R3

  AST_GRST_TRACKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    gctlWrite |=> (globalResetOut == $past(busWdata[GRST_BIT])) && (!globalResetOut || &portResetOut));  // R2

  AST_LINE_RISE_CAUSED: assert property (@(posedge clk) disable iff (rst)
    ((intLines & ~$past(intLines)) != '0) |-> $past((busValid && busWrite) || (|portEvent)));  // R9

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busValid && !busWrite && !mapped(busAddr)) |=> rdData == '0);  // R11

  for (genvar p = 0; p < PORTS; p++) begin : gChk
    AST_CTL_SET_RESET: assert property (@(posedge clk) disable iff (rst)
      (busValid && busWrite && busAddr == portBase(p) + OFS_CSET && busWdata[PRST_BIT]) |=> portResetOut[p]);  // R4
    AST_CTL_CLR_DEVRST: assert property (@(posedge clk) disable iff (rst)
      (busValid && busWrite && busAddr == portBase(p) + OFS_CCLR && busWdata[DRST_BIT]) |=> !devResetOut[p]);  // R4
  end
endmodule

bind port_irq_regs port_irq_regs_chk u_chk (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .portEvent(portEvent), .rdData(rdData), .intLines(intLines),
  .msiAck(msiAck), .globalResetOut(globalResetOut), .portResetOut(portResetOut),
  .devResetOut(devResetOut)
);

// File: tb/sim_port_irq_regs.sv
`timescale 1ns/1ps
module sim_port_irq_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [23:0] portEvent = '0;
  logic [31:0] rdData;
  logic [3:0]  intLines;
  logic        msiAck, globalResetOut;
  logic [1:0]  portResetOut, devResetOut, pmEnable;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  port_irq_regs u0 (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .portEvent(portEvent), .rdData(rdData), .intLines(intLines),
    .msiAck(msiAck), .globalResetOut(globalResetOut), .portResetOut(portResetOut),
    .devResetOut(devResetOut), .pmEnable(pmEnable)
  );

  // reference model state
  logic        mGRst;
  logic [1:0]  mGEn, mGSts;
  logic        mMsi;
  logic [31:0] mCtl [2];
  logic [11:0] mSts [2], mEn [2];
  logic [1:0]  mSteer [2];

  function automatic logic [15:0] pa(input int p, input logic [15:0] ofs);
    return 16'h1000 + 16'(p) * 16'h2000 + ofs;
  endfunction

  function automatic logic [31:0] mRead(input logic [15:0] a);
    if (a == 16'h0040) return {mGRst, 6'b0, 1'b1, 22'b0, mGEn};
    if (a == 16'h0044) return {30'b0, mGSts};
    for (int p = 0; p < 2; p++) begin
      if (a == pa(p, 0) || a == pa(p, 4)) return mCtl[p];
      if (a == pa(p, 8)) return {20'b0, mSts[p]};
      if (a == pa(p, 16'h10) || a == pa(p, 16'h14)) return {mSteer[p], 18'b0, mEn[p]};
    end
    return 32'h0;
  endfunction

  function automatic logic [3:0] mLines();
    logic [3:0] l = '0;
    for (int p = 0; p < 2; p++)
      if ((|(mSts[p] & mEn[p])) && mGEn[p]) l[mSteer[p]] = 1'b1;
    return l;
  endfunction

  task automatic modelReset();
    mGRst = 1'b1; mGEn = '0; mGSts = '0; mMsi = 1'b0;
    for (int p = 0; p < 2; p++) begin
      mCtl[p] = '0; mSts[p] = '0; mEn[p] = '0; mSteer[p] = '0;
    end
  endtask

  task automatic modelStep(input logic v, input logic w, input logic [15:0] a,
                           input logic [31:0] d, input logic [23:0] ev);
    logic [1:0] pendNow;
    for (int p = 0; p < 2; p++) pendNow[p] = |(mSts[p] & mEn[p]);
    mMsi = v && w && a == 16'h0040 && d[30];
    if (v && w && a == 16'h0044) mGSts = mGSts & ~d[1:0];
    mGSts = mGSts | pendNow;
    if (v && w && a == 16'h0040) begin mGRst = d[31]; mGEn = d[1:0]; end
    for (int p = 0; p < 2; p++) begin
      logic [11:0] e;
      e = ev[p*12 +: 12] & 12'h8FF;
      if (v && w && a == pa(p, 8)) mSts[p] = mSts[p] & ~d[11:0];
      if (v && !w && a == pa(p, 8) && !mCtl[p][3]) mSts[p][0] = 1'b0;
      mSts[p] = mSts[p] | e;
      if (v && w && a == pa(p, 0)) mCtl[p] = mCtl[p] | (d & 32'h200B);
      if (v && w && a == pa(p, 4)) mCtl[p] = mCtl[p] & ~(d & 32'h200B);
      if (v && w && a == pa(p, 16'h10)) begin mEn[p] = mEn[p] | (d[11:0] & 12'h8FF); mSteer[p] = d[31:30]; end
      if (v && w && a == pa(p, 16'h14)) mEn[p] = mEn[p] & ~(d[11:0] & 12'h8FF);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOuts();
    chk("R9 lines", {28'b0, intLines}, {28'b0, mLines()});
    chk("R3 msiAck", {31'b0, msiAck}, {31'b0, mMsi});
    chk("R2 globalReset", {31'b0, globalResetOut}, {31'b0, mGRst});
    chk("R4 portReset", {30'b0, portResetOut}, {30'b0, mCtl[1][0] | mGRst, mCtl[0][0] | mGRst});
    chk("R4 devReset", {30'b0, devResetOut}, {30'b0, mCtl[1][1], mCtl[0][1]});
    chk("R4 pmEnable", {30'b0, pmEnable}, {30'b0, mCtl[1][13], mCtl[0][13]});
  endtask

  // one bus cycle; returns the read data seen on the following cycle
  task automatic step(input logic v, input logic w, input logic [15:0] a,
                      input logic [31:0] d, input logic [23:0] ev, input string req,
                      output logic [31:0] got);
    logic [31:0] expRd;
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busWdata = d; portEvent = ev;
    expRd = (v && !w) ? mRead(a) : 32'h0;
    modelStep(v, w, a, d, ev);
    @(posedge clk);
    #1;
    busValid = 1'b0; busWrite = 1'b0; portEvent = '0;
    got = rdData;
    if (v && !w) chk(req, rdData, expRd);
    checkOuts();
  endtask

  logic [31:0] r;

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset values
    step(1, 0, 16'h0040, 0, 0, "R1 gctl", r); chk("R1 gctl literal", r, 32'h8100_0000);
    step(1, 0, 16'h0044, 0, 0, "R1 gsts", r); chk("R1 gsts literal", r, 32'h0);
    for (int p = 0; p < 2; p++) begin
      step(1, 0, pa(p, 0), 0, 0, "R1 ctl", r);
      step(1, 0, pa(p, 8), 0, 0, "R1 sts", r);
      step(1, 0, pa(p, 16'h10), 0, 0, "R1 en", r);
    end
    chk("R1 lines", {28'b0, intLines}, 32'h0);

    // R2 R3 global control
    step(1, 1, 16'h0040, 32'h7FFF_FFFF, 0, "R2", r);
    chk("R3 msi pulse", {31'b0, msiAck}, 32'h1);
    step(1, 0, 16'h0040, 0, 0, "R2 gctl read", r);
    chk("R2 gctl literal", r, 32'h0100_0003);
    chk("R3 msi single", {31'b0, msiAck}, 32'h0);

    // R4 control set/clear
    step(1, 1, pa(0, 0), 32'hFFFF_FFFF, 0, "R4", r);
    step(1, 0, pa(0, 4), 0, 0, "R4 ctl read", r); chk("R4 ctl literal", r, 32'h0000_200B);
    step(1, 1, pa(0, 4), 32'h0000_0001, 0, "R4", r);
    step(1, 0, pa(0, 0), 0, 0, "R4 ctl read", r); chk("R4 ctl after clear", r, 32'h0000_200A);

    // R5 events
    step(0, 0, 0, 0, 24'h000_FFF, "R5", r);
    step(1, 0, pa(0, 8), 0, 0, "R5 sts", r); chk("R5 sts literal", r, 32'h8FF);

    // R6 no-clear mode (ctl bit3 set), then clear-on-read mode
    step(1, 0, pa(0, 8), 0, 0, "R6 noclear", r); chk("R6 noclear literal", r, 32'h8FF);
    step(1, 1, pa(0, 4), 32'h0000_0008, 0, "R6", r);
    step(1, 0, pa(0, 8), 0, 0, "R6 cor", r); chk("R6 read before clear", r, 32'h8FF);
    step(1, 0, pa(0, 8), 0, 0, "R6 cor", r); chk("R6 completion cleared", r, 32'h8FE);

    // R7 event beats W1C in same cycle
    step(1, 1, pa(0, 8), 32'h0000_00FF, 24'h000_004, "R7", r);
    step(1, 0, pa(0, 8), 0, 0, "R7 sts", r); chk("R7 event wins", r, 32'h804);
    // R7 event beats clear-on-read
    step(1, 0, pa(0, 8), 0, 24'h000_001, "R7 cor", r);
    step(1, 0, pa(0, 8), 0, 0, "R7 cor", r); chk("R7 event wins read", r[0], 32'h1);

    // R8 R9 enables and steering
    step(1, 1, pa(0, 16'h10), 32'h8000_0004, 0, "R8", r);
    chk("R9 port0 on line C", {28'b0, intLines}, 32'h4);
    step(1, 1, pa(1, 0), 0, 24'h800_000, "R5", r);
    step(1, 1, pa(1, 16'h10), 32'hC000_0800, 0, "R8", r);
    chk("R9 two lines", {28'b0, intLines}, 32'hC);
    step(1, 0, pa(1, 16'h14), 0, 0, "R8 en read", r); chk("R8 en literal", r, 32'hC000_0800);
    step(1, 1, pa(0, 16'h14), 32'h0000_0004, 0, "R8", r);
    chk("R9 port0 off", {28'b0, intLines}, 32'h8);
    step(1, 1, 16'h0040, 32'h0000_0000, 0, "R9", r);
    chk("R9 global off", {28'b0, intLines}, 32'h0);

    // R10 sticky global pending
    step(1, 1, 16'h0044, 32'h3, 0, "R10", r);
    step(1, 0, 16'h0044, 0, 0, "R10 set wins", r); chk("R10 pending kept", r, 32'h2);
    step(1, 1, pa(1, 16'h14), 32'h0000_0800, 0, "R10", r);
    step(1, 0, 16'h0044, 0, 0, "R10 sticky", r); chk("R10 sticky literal", r, 32'h2);
    step(1, 1, 16'h0044, 32'h2, 0, "R10", r);
    step(1, 0, 16'h0044, 0, 0, "R10 cleared", r); chk("R10 cleared literal", r, 32'h0);

    // R11 unmapped
    step(1, 0, 16'h0800, 0, 0, "R11", r); chk("R11 literal", r, 32'h0);
    step(1, 0, pa(1, 16'h0C), 0, 0, "R11", r);

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      int k = $urandom % 13;
      logic [31:0] d = $urandom;
      logic [23:0] ev = 24'($urandom & $urandom & $urandom);
      if (k < 10) a = pa(k / 5, (k % 5 == 0) ? 16'h0 : (k % 5 == 1) ? 16'h4 :
                                 (k % 5 == 2) ? 16'h8 : (k % 5 == 3) ? 16'h10 : 16'h14);
      else if (k == 10) a = 16'h0040;
      else if (k == 11) a = 16'h0044;
      else a = 16'h0800;
      step(($urandom % 10) != 0, $urandom % 2, a, d, ev, "R5-model random read", r);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule